// File: doc/BRIEF.md
# Segmented Instruction Fetch Address Unit

This block keeps the code segment and the instruction pointer used for instruction fetch. It turns them into a 20-bit physical bus address on every fetch request. The physical address is the segment times sixteen plus the offset. Only the low 20 bits are kept, so a sum that runs past the top of the address space lands back in low memory. Each accepted fetch moves the offset forward by one byte, or by two in word mode. The offset wraps inside its 64 KiB segment and never carries into the segment.

A jump or far transfer rewrites both registers through the load port in a single cycle. After reset the pointer sits sixteen bytes below the top of the address space. A run of plain byte fetches therefore shows the upper address nibble high for sixteen fetches, then low for the remaining 65520 offsets, and the cycle repeats. The offset runs ahead of execution, because it counts fetched bytes and not executed instructions.

Top module: `seg_fetch_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `cur_seg` = FFFFh, `cur_off` = 0000h, `fetch_valid` = 0 and `fetch_addr` = 00000h.
- R2: A fetch is accepted when `fetch_req` = 1 and `load_en` = 0. One cycle later `fetch_valid` = 1 and `fetch_addr` holds (segment × 16 + offset) taken from the pointer as it stood before that fetch.
- R3: `fetch_addr` keeps only bits 19..0 of the sum. Segment FFFFh with offset 0010h gives 00000h, and segment FFFFh with offset FFFFh gives 0FFEFh.
- R4: A byte fetch (`word_mode` = 0) raises `cur_off` by 1 modulo 65536 and leaves `cur_seg` unchanged, so FFFFh is followed by 0000h.
- R5: A word fetch (`word_mode` = 1) raises `cur_off` by 2 modulo 65536 and leaves `cur_seg` unchanged, so FFFEh is followed by 0000h.
- R6: With `load_en` = 1, the next cycle shows `cur_seg` = `load_seg` and `cur_off` = `load_off`, and `fetch_valid` = 0.
- R7: When `load_en` and `fetch_req` are both high, the load wins. No increment is applied, `fetch_valid` stays 0 and `fetch_addr` keeps its value.
- R8: In a cycle with neither request, `cur_seg`, `cur_off` and `fetch_addr` hold, and `fetch_valid` is 0 the next cycle.
- R9: Starting from reset, continuous byte fetches give addresses FFFF0h..FFFFFh (16 fetches with bits 19..16 all ones), then 00000h..0FFEFh (65520 fetches with bits 19..16 all zeros), then FFFF0h again.
- R10: Reset takes priority over a load or a fetch requested in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | Request one fetch at the current pointer |
| word_mode | input | 1 | 0 = byte step of 1, 1 = word step of 2 |
| load_en | input | 1 | Replace segment and offset |
| load_seg | input | 16 | New segment value |
| load_off | input | 16 | New offset value |
| fetch_addr | output | 20 | Registered physical fetch address |
| cur_seg | output | 16 | Current code segment |
| cur_off | output | 16 | Current instruction pointer (post-advance) |
| fetch_valid | output | 1 | High for one cycle after each accepted fetch |

## Verification
Every result is registered, so each one appears exactly one clock edge after the stimulus that causes it. This covers the address and strobe of a fetch, the advanced pointer, the loaded pointer and the reset state. Inputs are driven on the falling edge and outputs are read on the next falling edge, half a period after the edge that updated them. The fetch driver pushes the expected address into a queue when it raises the request. The monitor pops one entry for each cycle in which the strobe is seen high, so an address that arrives early, late or not at all shows up as a miscompare or as a leftover entry.

// File: rtl/segfetch_pkg.sv
package segfetch_pkg;

    localparam int SEG_W     = 16;
    localparam int OFF_W     = 16;
    localparam int SEG_SHIFT = 4;
    localparam int PA_W      = 20;
    localparam int SUM_W     = ((SEG_W + SEG_SHIFT) > OFF_W ? (SEG_W + SEG_SHIFT) : OFF_W) + 1;

    typedef logic [SEG_W-1:0] seg_t;
    typedef logic [OFF_W-1:0] off_t;
    typedef logic [PA_W-1:0]  pa_t;

    localparam seg_t RESET_SEG = '1;
    localparam off_t RESET_OFF = '0;

    typedef enum logic {
        STEP_BYTE = 1'b0,
        STEP_WORD = 1'b1
    } step_e;

    typedef struct packed {
        seg_t seg;
        off_t off;
    } fptr_t;

    // Physical address: segment shifted left, offset added, carries above PA_W dropped.
    function automatic pa_t phys_addr(input seg_t s, input off_t o);
        logic [SUM_W-1:0] sum;
        sum = (SUM_W'(s) << SEG_SHIFT) + SUM_W'(o);
        return sum[PA_W-1:0];
    endfunction

    function automatic off_t step_amount(input step_e m);
        return (m == STEP_WORD) ? off_t'(2) : off_t'(1);
    endfunction

endpackage

// File: rtl/fetch_step_calc.sv
module fetch_step_calc
    import segfetch_pkg::*;
(
    input  off_t  cur_off,
    input  step_e mode,
    output off_t  nxt_off
);
    // Offset arithmetic is OFF_W wide, so it wraps inside the segment.
    always_comb begin
        nxt_off = cur_off + step_amount(mode);
    end
endmodule

// File: rtl/fetch_ptr_regs.sv
module fetch_ptr_regs
    import segfetch_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  advance,
    input  step_e mode,
    input  logic  load,
    input  fptr_t load_ptr,
    output fptr_t ptr
);
    off_t nxt_off;

    fetch_step_calc u_step (
        .cur_off (ptr.off),
        .mode    (mode),
        .nxt_off (nxt_off)
    );

    // Priority: reset, then load, then advance.
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr.seg <= RESET_SEG;
            ptr.off <= RESET_OFF;
        end else if (load) begin
            ptr <= load_ptr;
        end else if (advance) begin
            ptr.off <= nxt_off;
        end
    end
endmodule

// File: rtl/fetch_addr_reg.sv
module fetch_addr_reg
    import segfetch_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  issue,
    input  fptr_t ptr,
    output pa_t   addr,
    output logic  valid
);
    pa_t addr_next;

    always_comb begin
        addr_next = phys_addr(ptr.seg, ptr.off);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= issue;
            if (issue) begin
                addr <= addr_next;
            end
        end
    end
endmodule

// File: rtl/seg_fetch_unit.sv
module seg_fetch_unit
    import segfetch_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fetch_req,
    input  logic             word_mode,
    input  logic             load_en,
    input  logic [SEG_W-1:0] load_seg,
    input  logic [OFF_W-1:0] load_off,
    output logic [PA_W-1:0]  fetch_addr,
    output logic [SEG_W-1:0] cur_seg,
    output logic [OFF_W-1:0] cur_off,
    output logic             fetch_valid
);
    fptr_t ptr;
    fptr_t load_ptr;
    logic  issue;
    step_e mode;

    // A load in the same cycle suppresses the fetch.
    assign issue        = fetch_req & ~load_en;
    assign mode         = step_e'(word_mode);
    assign load_ptr.seg = load_seg;
    assign load_ptr.off = load_off;

    fetch_ptr_regs u_ptr (
        .clk      (clk),
        .rst      (rst),
        .advance  (issue),
        .mode     (mode),
        .load     (load_en),
        .load_ptr (load_ptr),
        .ptr      (ptr)
    );

    fetch_addr_reg u_addr (
        .clk   (clk),
        .rst   (rst),
        .issue (issue),
        .ptr   (ptr),
        .addr  (fetch_addr),
        .valid (fetch_valid)
    );

    assign cur_seg = ptr.seg;
    assign cur_off = ptr.off;
endmodule

// File: rtl/seg_fetch_chk.sv
module seg_fetch_chk
    import segfetch_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             fetch_req,
    input logic             word_mode,
    input logic             load_en,
    input logic [SEG_W-1:0] load_seg,
    input logic [OFF_W-1:0] load_off,
    input logic [PA_W-1:0]  fetch_addr,
    input logic [SEG_W-1:0] cur_seg,
    input logic [OFF_W-1:0] cur_off,
    input logic             fetch_valid
);
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (cur_seg == RESET_SEG && cur_off == RESET_OFF && !fetch_valid && fetch_addr == '0));

    p_fetch_addr_r2: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && !load_en) |=> (fetch_valid && fetch_addr == phys_addr($past(cur_seg), $past(cur_off))));

    p_byte_step_r4: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && !load_en && !word_mode) |=> (cur_off == off_t'($past(cur_off) + off_t'(1)) && $stable(cur_seg)));

    p_word_step_r5: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && !load_en && word_mode) |=> (cur_off == off_t'($past(cur_off) + off_t'(2)) && $stable(cur_seg)));

    p_load_r6: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (cur_seg == $past(load_seg) && cur_off == $past(load_off) && !fetch_valid));

    p_load_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (load_en && fetch_req) |=> ($stable(fetch_addr) && !fetch_valid));

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !fetch_req) |=> ($stable(cur_seg) && $stable(cur_off) && $stable(fetch_addr) && !fetch_valid));
endmodule

bind seg_fetch_unit seg_fetch_chk u_chk (.*);

// File: tb/tb_seg_fetch_unit.sv
`timescale 1ns/1ps
module tb_seg_fetch_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_req = 1'b0;
    logic        word_mode = 1'b0;
    logic        load_en = 1'b0;
    logic [15:0] load_seg = '0;
    logic [15:0] load_off = '0;
    logic [19:0] fetch_addr;
    logic [15:0] cur_seg;
    logic [15:0] cur_off;
    logic        fetch_valid;

    always #2.5 clk = ~clk;

    seg_fetch_unit dut (
        .clk         (clk),
        .rst         (rst),
        .fetch_req   (fetch_req),
        .word_mode   (word_mode),
        .load_en     (load_en),
        .load_seg    (load_seg),
        .load_off    (load_off),
        .fetch_addr  (fetch_addr),
        .cur_seg     (cur_seg),
        .cur_off     (cur_off),
        .fetch_valid (fetch_valid)
    );

    typedef struct {
        logic [19:0] addr;
        int          rq;
    } exp_t;

    exp_t        sb_q[$];
    exp_t        mon_e;
    int          vectors = 0;
    int          miscompares = 0;
    logic [15:0] m_seg;
    logic [15:0] m_off;

    function automatic logic [19:0] model_addr(input logic [15:0] s, input logic [15:0] o);
        return {s, 4'h0} + {4'h0, o};
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    // Monitor: one expected address per strobe.
    always @(negedge clk) begin
        if (!rst && fetch_valid) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R2 unexpected strobe", 32'(fetch_addr), 32'hX);
            end else begin
                mon_e = sb_q.pop_front();
                vectors++;
                if (fetch_addr !== mon_e.addr) begin
                    miscompares++;
                    $display("FAIL R%0d addr actual=%0h expected=%0h", mon_e.rq, fetch_addr, mon_e.addr);
                end
            end
        end
    end

    // Driver: one fetch, checking the advanced pointer one edge later (R4/R5).
    task automatic do_fetch(input logic word, input logic [19:0] exp_addr, input int rq);
        exp_t e;
        e.addr = exp_addr;
        e.rq   = rq;
        sb_q.push_back(e);
        fetch_req = 1'b1;
        word_mode = word;
        @(negedge clk);
        fetch_req = 1'b0;
        m_off = m_off + (word ? 16'd2 : 16'd1);
        chk(cur_off == m_off, word ? "R5 offset step" : "R4 offset step", 32'(cur_off), 32'(m_off));
        chk(cur_seg == m_seg, "R4 segment held", 32'(cur_seg), 32'(m_seg));
    endtask

    task automatic do_load(input logic [15:0] s, input logic [15:0] o, input logic with_fetch);
        logic [19:0] prev;
        prev      = fetch_addr;
        load_en   = 1'b1;
        load_seg  = s;
        load_off  = o;
        fetch_req = with_fetch;
        @(negedge clk);
        load_en   = 1'b0;
        fetch_req = 1'b0;
        m_seg = s;
        m_off = o;
        chk(cur_seg == s && cur_off == o, "R6 load pointer", {cur_seg, cur_off}, {s, o});
        chk(!fetch_valid, with_fetch ? "R7 no strobe" : "R6 no strobe", 32'(fetch_valid), 32'd0);
        if (with_fetch)
            chk(fetch_addr == prev, "R7 address held", 32'(fetch_addr), 32'(prev));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(cur_seg == 16'hFFFF && cur_off == 16'h0000, "R1 reset pointer", {cur_seg, cur_off}, 32'hFFFF0000);
        chk(!fetch_valid && fetch_addr == 20'h0, "R1 reset outputs", {11'h0, fetch_valid, fetch_addr}, 32'd0);
        rst = 1'b0;
        m_seg = 16'hFFFF;
        m_off = 16'h0000;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [19:0] hold_a;
        @(negedge clk);
        do_reset();

        // R2: plain byte fetches from the reset pointer.
        do_fetch(1'b0, 20'hFFFF0, 2);
        do_fetch(1'b0, 20'hFFFF1, 2);
        do_fetch(1'b0, 20'hFFFF2, 2);
        // R5: word fetches.
        do_fetch(1'b1, 20'hFFFF3, 5);
        do_fetch(1'b1, 20'hFFFF5, 5);

        // R6 and R5 wrap: 1234:FFFE word fetch -> offset 0000.
        do_load(16'h1234, 16'hFFFE, 1'b0);
        do_fetch(1'b1, 20'h2233E, 5);
        chk(cur_off == 16'h0000, "R5 word wrap", 32'(cur_off), 32'd0);

        // R4 byte wrap.
        do_load(16'h1234, 16'hFFFF, 1'b0);
        do_fetch(1'b0, 20'h2233F, 4);
        chk(cur_off == 16'h0000 && cur_seg == 16'h1234, "R4 byte wrap", {cur_seg, cur_off}, 32'h12340000);

        // R3: carry out of bit 19 is dropped.
        do_load(16'hFFFF, 16'h0010, 1'b0);
        do_fetch(1'b0, 20'h00000, 3);
        do_load(16'hFFFF, 16'hFFFF, 1'b0);
        do_fetch(1'b0, 20'h0FFEF, 3);
        do_load(16'hABCD, 16'h8001, 1'b0);
        do_fetch(1'b0, 20'hB3CD1, 2);

        // R7: load wins over a simultaneous fetch.
        do_load(16'h0400, 16'h0020, 1'b1);
        do_fetch(1'b0, 20'h04020, 7);

        // R8: idle cycle holds everything.
        hold_a = fetch_addr;
        @(negedge clk);
        chk(!fetch_valid, "R8 strobe low", 32'(fetch_valid), 32'd0);
        chk(fetch_addr == hold_a && cur_off == m_off && cur_seg == m_seg, "R8 state held",
            32'(fetch_addr), 32'(hold_a));

        // R10: reset beats load and fetch.
        rst = 1'b1;
        load_en = 1'b1;
        load_seg = 16'h5555;
        load_off = 16'h6666;
        fetch_req = 1'b1;
        @(negedge clk);
        load_en = 1'b0;
        fetch_req = 1'b0;
        chk(cur_seg == 16'hFFFF && cur_off == 16'h0000 && !fetch_valid, "R10 reset priority",
            {cur_seg, cur_off}, 32'hFFFF0000);
        do_reset();

        // R9: full byte sweep from reset, expected addresses counted, not computed.
        for (int i = 0; i < 65536 + 16; i++) begin
            logic [19:0] ea;
            if (i < 16)         ea = 20'hFFFF0 + 20'(i);
            else if (i < 65536) ea = 20'(i - 16);
            else                ea = 20'hFFFF0 + 20'(i - 65536);
            do_fetch(1'b0, ea, 9);
        end
        chk(cur_off == 16'h0010, "R9 pointer after sweep", 32'(cur_off), 32'h10);

        @(negedge clk);
        @(negedge clk);
        chk(sb_q.size() == 0, "R2 all fetches returned", 32'(sb_q.size()), 32'd0);
        summary();
        $finish;
    end

endmodule